// File: doc/BRIEF.md
# Console Keyboard and Display Port Controller

This block is a small peripheral on a processor's word-wide register bus. It connects one incoming keystroke stream and one outgoing character stream to software. It decodes a 16-byte window at a base address chosen by a parameter. Inside that window there is one status/control word and one data word for each direction.

Software can poll the ready flags. It can also set a per-direction enable so that a ready flag drives an interrupt line. A received byte is latched with its ready flag set, and the flag clears when software reads the byte. A byte written for display is offered on a valid/accept handshake. The display-side ready flag stays low until the sink accepts that byte.

Top module: `console_mmio`

## Requirements
- R1: After reset, receive ready reads 0 and transmit ready reads 1. Both interrupt enables read 0, both interrupt lines are low, and `disp_valid` is low.
- R2: The window offsets from BASE are 0x0 for receive control, 0x4 for receive data, 0x8 for transmit control and 0xC for transmit data. An access whose upper address bits (above bit 3) differ from BASE reads 0 and has no effect.
- R3: A cycle with `kb_valid` high stores `kb_byte`, and receive ready (bit 0 of receive control) reads 1 from the next cycle. Receive data returns the byte in bits 7:0, with bits 31:8 at 0.
- R4: A read of receive data clears receive ready from the next cycle. If `kb_valid` is high in the same cycle as that read, the new byte is stored and ready stays 1.
- R5: A byte arriving while receive ready is already 1 replaces the stored byte, and ready stays 1.
- R6: In both control words, bit 1 is a read/write interrupt enable. Writes to bit 0 are ignored. Bits 31:2 read 0.
- R7: A write to transmit data while transmit ready is 1 puts `bus_wdata[7:0]` on `disp_byte` with `disp_valid` high from the next cycle, and transmit ready reads 0 from then on.
- R8: While `disp_valid` is high and `disp_accept` is low, `disp_byte` and `disp_valid` hold. The cycle after `disp_accept` is seen with `disp_valid`, `disp_valid` is low and transmit ready reads 1.
- R9: A write to transmit data while transmit ready is 0 is discarded. The byte being offered is unchanged.
- R10: `irq_rx` is high exactly while receive ready and receive enable are both 1. `irq_tx` is high exactly while transmit ready and transmit enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects occur at the clock edge) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| kb_byte | input | 8 | Incoming keystroke byte |
| kb_valid | input | 1 | One-cycle strobe marking `kb_byte` valid |
| disp_byte | output | 8 | Byte offered to the display sink |
| disp_valid | output | 1 | `disp_byte` is pending |
| disp_accept | input | 1 | Sink takes the pending byte |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The hardest case to reach is the collision in which a keystroke arrives in the same clock as the software read that would clear receive ready. The bench reaches it by raising `kb_valid` and the receive-data read strobe on the same falling edge. It then checks that the flag survives and that the later byte is returned. A second case is a display write issued while a previous byte is still unaccepted. The bench reaches it by holding `disp_accept` low across a second write to the data word.

// File: rtl/cio_pkg.sv
package cio_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int RDY_BIT = 0;
  localparam int IEN_BIT = 1;

  typedef enum logic [1:0] {
    SLOT_RX_CTRL = 2'd0,
    SLOT_RX_DATA = 2'd1,
    SLOT_TX_CTRL = 2'd2,
    SLOT_TX_DATA = 2'd3
  } cio_slot_e;

  function automatic logic [WORD_W-1:0] pack_ctrl(input logic rdy, input logic ien);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RDY_BIT] = rdy;
    w[IEN_BIT] = ien;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_data(input logic [BYTE_W-1:0] b);
    logic [WORD_W-1:0] w;
    w = '0;
    w[BYTE_W-1:0] = b;
    return w;
  endfunction

  function automatic cio_slot_e slot_of(input logic [1:0] idx);
    return cio_slot_e'(idx);
  endfunction
endpackage

// File: rtl/cio_decode.sv
module cio_decode
  import cio_pkg::*;
#(
  parameter int              ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              hit,
  output cio_slot_e         slot,
  output logic              wr_rx_ctrl,
  output logic              wr_tx_ctrl,
  output logic              wr_tx_data,
  output logic              rd_rx_data
);
  generate
    if (ADDR_W > 4) begin : g_window
      assign hit = (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
    end else begin : g_full
      assign hit = 1'b1;
    end
  endgenerate

  logic unused_lsb;
  assign unused_lsb = ^addr[1:0];

  assign slot       = slot_of(addr[3:2]);
  assign wr_rx_ctrl = hit && wr && (slot == SLOT_RX_CTRL);
  assign wr_tx_ctrl = hit && wr && (slot == SLOT_TX_CTRL);
  assign wr_tx_data = hit && wr && (slot == SLOT_TX_DATA);
  assign rd_rx_data = hit && rd && (slot == SLOT_RX_DATA);
endmodule

// File: rtl/cio_rx_chan.sv
module cio_rx_chan
  import cio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_valid,
  input  logic              take,
  input  logic              ctrl_wr,
  input  logic              ien_d,
  output logic              rdy,
  output logic              ien,
  output logic [BYTE_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      ien  <= 1'b0;
      data <= '0;
    end else begin
      if (in_valid) begin
        data <= in_byte;
        rdy  <= 1'b1;
      end else if (take) begin
        rdy <= 1'b0;
      end
      if (ctrl_wr) ien <= ien_d;
    end
  end
endmodule

// File: rtl/cio_tx_chan.sv
module cio_tx_chan
  import cio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              ctrl_wr,
  input  logic              ien_d,
  input  logic              accept,
  output logic              rdy,
  output logic              ien,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid,
  output logic              ev_load,
  output logic              ev_done
);
  assign ev_load   = load && rdy;
  assign ev_done   = !rdy && accept;
  assign out_valid = !rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy      <= 1'b1;
      ien      <= 1'b0;
      out_byte <= '0;
    end else begin
      if (ev_load) begin
        out_byte <= load_byte;
        rdy      <= 1'b0;
      end else if (ev_done) begin
        rdy <= 1'b1;
      end
      if (ctrl_wr) ien <= ien_d;
    end
  end
endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import cio_pkg::*;
#(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        kb_byte,
  input  logic              kb_valid,
  output logic [7:0]        disp_byte,
  output logic              disp_valid,
  input  logic              disp_accept,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic      hit;
  cio_slot_e slot;
  logic      wr_rx_ctrl, wr_tx_ctrl, wr_tx_data, rd_rx_data;
  logic      rx_rdy, rx_ien, tx_rdy, tx_ien;
  logic [BYTE_W-1:0] rx_data;
  logic      ev_tx_load, ev_tx_done;

  logic unused_hi;
  assign unused_hi = ^bus_wdata[WORD_W-1:BYTE_W];

  cio_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .hit(hit), .slot(slot),
    .wr_rx_ctrl(wr_rx_ctrl), .wr_tx_ctrl(wr_tx_ctrl),
    .wr_tx_data(wr_tx_data), .rd_rx_data(rd_rx_data)
  );

  cio_rx_chan u_rx (
    .clk(clk), .rst_n(rst_n), .in_byte(kb_byte), .in_valid(kb_valid),
    .take(rd_rx_data), .ctrl_wr(wr_rx_ctrl), .ien_d(bus_wdata[IEN_BIT]),
    .rdy(rx_rdy), .ien(rx_ien), .data(rx_data)
  );

  cio_tx_chan u_tx (
    .clk(clk), .rst_n(rst_n), .load(wr_tx_data), .load_byte(bus_wdata[BYTE_W-1:0]),
    .ctrl_wr(wr_tx_ctrl), .ien_d(bus_wdata[IEN_BIT]), .accept(disp_accept),
    .rdy(tx_rdy), .ien(tx_ien), .out_byte(disp_byte), .out_valid(disp_valid),
    .ev_load(ev_tx_load), .ev_done(ev_tx_done)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      unique case (slot)
        SLOT_RX_CTRL: bus_rdata = pack_ctrl(rx_rdy, rx_ien);
        SLOT_RX_DATA: bus_rdata = pack_data(rx_data);
        SLOT_TX_CTRL: bus_rdata = pack_ctrl(tx_rdy, tx_ien);
        SLOT_TX_DATA: bus_rdata = '0;
        default:      bus_rdata = '0;
      endcase
    end
  end

  assign irq_rx = rx_rdy && rx_ien;
  assign irq_tx = tx_rdy && tx_ien;
endmodule

// File: rtl/console_mmio_chk.sv
module console_mmio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       kb_valid,
  input logic       rd_rx_data,
  input logic       wr_rx_ctrl,
  input logic       wr_tx_ctrl,
  input logic       wr_tx_data,
  input logic       rx_rdy,
  input logic       tx_rdy,
  input logic       ev_tx_load,
  input logic       ev_tx_done,
  input logic [7:0] wbyte,
  input logic [7:0] disp_byte,
  input logic       disp_valid,
  input logic       disp_accept,
  input logic       irq_tx
);
  assert_rx_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid |=> rx_rdy);

  assert_rx_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx_data && !kb_valid) |=> !rx_rdy);

  assert_rdy_wr_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rx_ctrl && !kb_valid && !rx_rdy) |=> !rx_rdy);

  assert_tx_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_load |=> (disp_valid && disp_byte == $past(wbyte)));

  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_accept) |=> (disp_valid && $stable(disp_byte)));

  assert_tx_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx_data && !tx_rdy) |=> $stable(disp_byte));

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx) |-> ($past(ev_tx_done) || $past(wr_tx_ctrl)));
endmodule

bind console_mmio console_mmio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .kb_valid(kb_valid), .rd_rx_data(rd_rx_data),
  .wr_rx_ctrl(wr_rx_ctrl), .wr_tx_ctrl(wr_tx_ctrl), .wr_tx_data(wr_tx_data),
  .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .ev_tx_load(ev_tx_load), .ev_tx_done(ev_tx_done),
  .wbyte(bus_wdata[7:0]), .disp_byte(disp_byte), .disp_valid(disp_valid),
  .disp_accept(disp_accept), .irq_tx(irq_tx)
);

// File: tb/console_mmio_tb.sv
module console_mmio_tb;
  localparam logic [31:0] BASE = 32'hFFFF_0000;
  localparam logic [31:0] A_RXC = BASE + 32'h0;
  localparam logic [31:0] A_RXD = BASE + 32'h4;
  localparam logic [31:0] A_TXC = BASE + 32'h8;
  localparam logic [31:0] A_TXD = BASE + 32'hC;
  localparam int NVEC = 5;
  // {received byte, byte to display}
  localparam logic [15:0] VEC [NVEC] = '{16'h71_41, 16'h00_FF, 16'hA5_5A, 16'hFF_00, 16'h3C_C3};

  logic clk = 0, rst_n = 0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] kb_byte = '0, disp_byte;
  logic kb_valid = 0, disp_valid, disp_accept = 0, irq_rx, irq_tx;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  console_mmio #(.ADDR_W(32), .BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kb_byte(kb_byte), .kb_valid(kb_valid),
    .disp_byte(disp_byte), .disp_valid(disp_valid), .disp_accept(disp_accept),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic key(input logic [7:0] b);
    @(negedge clk); kb_byte = b; kb_valid = 1;
    @(negedge clk); kb_valid = 0;
  endtask

  task automatic take_disp();
    @(negedge clk); disp_accept = 1;
    @(negedge clk); disp_accept = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1 irq_rx", {31'b0, irq_rx}, 0);
    check("R1 irq_tx", {31'b0, irq_tx}, 0);
    check("R1 disp_valid", {31'b0, disp_valid}, 0);
    rd(A_RXC, v); check("R1 rx ctrl", v, 32'h0);
    rd(A_TXC, v); check("R1 tx ctrl", v, 32'h1);

    // table walk: R3 R4 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      key(VEC[i][15:8]);
      rd(A_RXC, v); check("R3 rx ready", v, 32'h1);
      rd(A_RXD, v); check("R3 rx data", v, {24'b0, VEC[i][15:8]});
      rd(A_RXC, v); check("R4 ready cleared", v, 32'h0);
      wr(A_TXD, {24'hABCDEF, VEC[i][7:0]});
      check("R7 disp_valid", {31'b0, disp_valid}, 1);
      check("R7 disp_byte", {24'b0, disp_byte}, {24'b0, VEC[i][7:0]});
      rd(A_TXC, v); check("R7 tx busy", v, 32'h0);
      repeat (2) @(negedge clk);
      check("R8 hold byte", {24'b0, disp_byte}, {24'b0, VEC[i][7:0]});
      check("R8 hold valid", {31'b0, disp_valid}, 1);
      take_disp();
      check("R8 valid drops", {31'b0, disp_valid}, 0);
      rd(A_TXC, v); check("R8 tx ready back", v, 32'h1);
    end

    // R2 outside window
    wr(BASE + 32'h10, 32'h2);
    rd(A_RXC, v); check("R2 foreign write ignored", v, 32'h0);
    key(8'h55);
    rd(BASE + 32'h14, v); check("R2 foreign read zero", v, 32'h0);
    rd(A_RXC, v); check("R2 foreign read no clear", v, 32'h1);
    rd(A_RXD, v); check("R2 data offset", v, 32'h55);

    // R5 overwrite
    key(8'h11); key(8'h22);
    rd(A_RXC, v); check("R5 ready stays", v, 32'h1);
    rd(A_RXD, v); check("R5 newest byte", v, 32'h22);

    // R4 collision: read and arrival in same cycle
    key(8'h33);
    @(negedge clk); bus_addr = A_RXD; bus_rd = 1; kb_byte = 8'h44; kb_valid = 1;
    @(negedge clk); bus_rd = 0; kb_valid = 0;
    rd(A_RXC, v); check("R4 collision ready", v, 32'h1);
    rd(A_RXD, v); check("R4 collision data", v, 32'h44);

    // R6 control bits
    wr(A_RXC, 32'hFFFF_FFFF);
    rd(A_RXC, v); check("R6 rx ctrl mask", v, 32'h2);
    wr(A_TXC, 32'hFFFF_FFFC);
    rd(A_TXC, v); check("R6 tx ready not writable", v, 32'h1);

    // R10 interrupts (rx enable is 1 here, rx ready 0)
    check("R10 irq_rx idle", {31'b0, irq_rx}, 0);
    key(8'h66);
    check("R10 irq_rx set", {31'b0, irq_rx}, 1);
    rd(A_RXD, v);
    check("R10 irq_rx clear", {31'b0, irq_rx}, 0);
    wr(A_TXC, 32'h2);
    check("R10 irq_tx set", {31'b0, irq_tx}, 1);

    // R9 write while busy
    wr(A_TXD, 32'h11);
    check("R10 irq_tx busy", {31'b0, irq_tx}, 0);
    wr(A_TXD, 32'h22);
    check("R9 busy write dropped", {24'b0, disp_byte}, 32'h11);
    take_disp();
    check("R9 single byte", {31'b0, disp_valid}, 0);
    check("R10 irq_tx back", {31'b0, irq_tx}, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule